// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block is the sending half of an interprocessor interrupt path. Software programs two 32-bit command words through a small memory-mapped register port. The high word holds the destination processor identifier. The low word holds the vector, the delivery mode, the trigger and level controls, and a broadcast flag.

A write to the low word launches one message on a valid/ready output port. The message is a snapshot of both words taken at the moment of launch. While that message waits for acceptance, a busy flag can be read back in bit 12 of the low word. Software polls that bit to learn when the message has gone.

A launch attempt made while busy is refused, and a sticky error output records it. The receiving side, arbitration and the meaning of the message at the target are outside this block.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, both command words read as 0, `msg_valid` is 0 and `err_sticky` is 0.
- R2: A write at byte offset 0x310 stores the high word, and reading 0x310 returns it unchanged. Bits 31:24 of that word form the destination identifier.
- R3: A write at byte offset 0x300 while not busy raises `msg_valid` on the next clock edge. From that edge, bit 12 of a read at 0x300 is 1.
- R4: The launched message carries these low-word fields: vector from bits 7:0, delivery mode from bits 10:8 (0 fixed, 5 INIT, 6 STARTUP), level assert from bit 14 and level trigger from bit 15. The destination is taken from bits 31:24 of the high word.
- R5: When bit 19 of the low word is set, the message is a broadcast. `msg_bcast` is 1 and `msg_dest` is all ones, whatever the high word holds.
- R6: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and every message field stays constant. This holds even if either command word is rewritten.
- R7: A cycle with both `msg_valid` and `msg_ready` high clears `msg_valid` on the next edge. From then on, bit 12 of a read at 0x300 is 0.
- R8: A write at 0x300 while busy is ignored: the stored low word and the pending message keep their values. `err_sticky` becomes 1 and stays 1 until reset.
- R9: A read at 0x300 returns the last accepted low word, with bit 12 replaced by the live busy flag. The value software wrote into bit 12 has no effect.
- R10: Writes at any offset other than 0x300 and 0x310 change no state. Reads at such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Receiver accepts message |
| msg_dest | output | 8 | Destination identifier (all ones on broadcast) |
| msg_vector | output | 8 | Vector or start page number |
| msg_mode | output | 3 | Delivery mode |
| msg_assert | output | 1 | Level assert (1) or deassert (0) |
| msg_level | output | 1 | Level-triggered (1) or edge (0) |
| msg_bcast | output | 1 | Broadcast to all, sender included |
| err_sticky | output | 1 | A launch was attempted while busy |

## Verification
The bench builds the unit with its default parameters: 12-bit offsets, the two command words at 0x300 and 0x310, and an 8-bit identifier. This keeps the control space small. It covers every combination of the eight delivery modes, assert, trigger and broadcast, which is 64 launches. Each launch uses a computed vector and destination, a varying acceptance delay, and alternating values written into the status bit. Separate sequences exercise a refused launch, a high-word rewrite under a pending message, and writes to an unmapped offset.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int ID_W   = 8;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;

    // Field positions inside the command words
    localparam int ID_LSB     = 24;
    localparam int MODE_LSB   = 8;
    localparam int BUSY_BIT   = 12;
    localparam int ASSERT_BIT = 14;
    localparam int LEVEL_BIT  = 15;
    localparam int BCAST_BIT  = 19;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMGMT  = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_RSV7   = 3'd7
    } dmode_e;

    typedef struct packed {
        logic [ID_W-1:0]  dest;
        logic             bcast;
        logic             level;
        logic             lvl_assert;
        dmode_e           mode;
        logic [VEC_W-1:0] vector;
    } ipi_msg_t;

    function automatic ipi_msg_t form_msg(input logic [WORD_W-1:0] hi,
                                          input logic [WORD_W-1:0] lo);
        ipi_msg_t m;
        m.bcast      = lo[BCAST_BIT];
        m.dest       = lo[BCAST_BIT] ? {ID_W{1'b1}} : hi[ID_LSB +: ID_W];
        m.level      = lo[LEVEL_BIT];
        m.lvl_assert = lo[ASSERT_BIT];
        m.mode       = dmode_e'(lo[MODE_LSB +: MODE_W]);
        m.vector     = lo[VEC_W-1:0];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] with_busy(input logic [WORD_W-1:0] w,
                                                    input logic busy);
        logic [WORD_W-1:0] r;
        r = w;
        r[BUSY_BIT] = busy;
        return r;
    endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
    parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic [WORD_W-1:0] hi_q,
    output logic [WORD_W-1:0] lo_q,
    output logic              launch,
    output logic              reject,
    output logic [WORD_W-1:0] rdata
);

    logic hit_lo, hit_hi;

    assign hit_lo = (addr == LO_OFF);
    assign hit_hi = (addr == HI_OFF);
    assign launch = we && hit_lo && !busy;
    assign reject = we && hit_lo && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (we && hit_hi) hi_q <= wdata;
            if (launch)       lo_q <= wdata;
        end
    end

    always_comb begin
        if (hit_lo)      rdata = with_busy(lo_q, busy);
        else if (hit_hi) rdata = hi_q;
        else             rdata = '0;
    end

    AST_REJECT_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        reject |=> $stable(lo_q)) else $error("rejected write changed low word"); // R8
    AST_HI_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        (we && hit_hi) |=> (hi_q == $past(wdata))) else $error("high word not stored"); // R2

endmodule

// File: rtl/ipi_cmd_launch.sv
module ipi_cmd_launch
    import ipi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  logic     reject,
    input  ipi_msg_t msg_in,
    input  logic     ready,
    output logic     valid,
    output ipi_msg_t msg_q,
    output logic     err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg_q <= '0;
            err   <= 1'b0;
        end else begin
            if (launch) begin
                valid <= 1'b1;
                msg_q <= msg_in;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
            if (reject) err <= 1'b1;
        end
    end

    AST_LAUNCH_RAISES: assert property (@(posedge clk) disable iff (rst)
        launch |=> valid) else $error("launch did not raise valid"); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(msg_q))) else $error("message moved while waiting"); // R6
    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !valid) else $error("valid held after accept"); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err) else $error("error flag dropped"); // R8

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFF = 12'h300,
    parameter logic [ADDR_W-1:0] HI_OFF = 12'h310
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_dest,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_assert,
    output logic              msg_level,
    output logic              msg_bcast,
    output logic              err_sticky
);

    logic [WORD_W-1:0] hi_q, lo_q;
    logic              launch, reject;
    ipi_msg_t          next_msg, cur_msg;

    ipi_cmd_regs #(
        .ADDR_W (ADDR_W),
        .LO_OFF (LO_OFF),
        .HI_OFF (HI_OFF)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (msg_valid),
        .hi_q   (hi_q),
        .lo_q   (lo_q),
        .launch (launch),
        .reject (reject),
        .rdata  (reg_rdata)
    );

    // Snapshot uses the current high word and the incoming low word
    assign next_msg = form_msg(hi_q, reg_wdata);

    ipi_cmd_launch u_launch (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .reject (reject),
        .msg_in (next_msg),
        .ready  (msg_ready),
        .valid  (msg_valid),
        .msg_q  (cur_msg),
        .err    (err_sticky)
    );

    assign msg_dest   = cur_msg.dest;
    assign msg_vector = cur_msg.vector;
    assign msg_mode   = cur_msg.mode;
    assign msg_assert = cur_msg.lvl_assert;
    assign msg_level  = cur_msg.level;
    assign msg_bcast  = cur_msg.bcast;

    AST_BCAST_DEST: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_bcast) |-> (msg_dest == '1)) else $error("broadcast dest not all ones"); // R5
    AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == LO_OFF) |-> (reg_rdata[BUSY_BIT] == msg_valid)) else $error("busy bit mismatch"); // R9

endmodule

// File: tb/ipi_cmd_unit_test.sv
module ipi_cmd_unit_test;

    localparam int PERIOD = 10;
    localparam logic [11:0] LO = 12'h300;
    localparam logic [11:0] HI = 12'h310;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = 12'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_assert, msg_level, msg_bcast, err_sticky;

    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    ipi_cmd_unit uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_assert(msg_assert), .msg_level(msg_level),
        .msg_bcast(msg_bcast), .err_sticky(err_sticky)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [23:0] exp_msg(input logic [31:0] hi, input logic [31:0] lo);
        logic [7:0] dest;
        dest = lo[19] ? 8'hFF : hi[31:24];
        return {dest, lo[7:0], lo[10:8], lo[14], lo[15], lo[19], 2'b00};
    endfunction

    function automatic logic [23:0] act_msg();
        return {msg_dest, msg_vector, msg_mode, msg_assert, msg_level, msg_bcast, 2'b00};
    endfunction

    task automatic accept();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, hi_w, lo_w, lo_a, hi_b;
        logic [23:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(LO, r); check("R1 lo", r, 32'h0);
        rd(HI, r); check("R1 hi", r, 32'h0);
        check("R1 valid", {31'h0, msg_valid}, 32'h0);
        check("R1 err", {31'h0, err_sticky}, 32'h0);

        // Sweep: all modes x assert x level x broadcast
        for (int i = 0; i < 64; i++) begin
            hi_w = {8'((i * 11 + 3) & 255), 24'((i * 4093) & 24'hFFFFFF)};
            lo_w = 32'h0;
            lo_w[7:0]   = 8'((i * 37 + 5) & 255);
            lo_w[10:8]  = 3'(i & 7);
            lo_w[12]    = i[0];           // R9 written status bit has no effect
            lo_w[14]    = i[3];
            lo_w[15]    = i[4];
            lo_w[19]    = i[5];
            wr(HI, hi_w);
            rd(HI, r); check("R2 hi readback", r, hi_w);
            wr(LO, lo_w);
            check("R3 valid after launch", {31'h0, msg_valid}, 32'h1);
            check("R4 R5 fields", {8'h0, act_msg()}, {8'h0, exp_msg(hi_w, lo_w)});
            rd(LO, r);
            check("R3 R9 lo readback busy", r, {lo_w[31:13], 1'b1, lo_w[11:0]});
            for (int k = 0; k < (i % 3); k++) begin
                @(negedge clk);
                check("R6 hold", {7'h0, msg_valid, act_msg()}, {7'h0, 1'b1, exp_msg(hi_w, lo_w)});
            end
            accept();
            check("R7 valid dropped", {31'h0, msg_valid}, 32'h0);
            rd(LO, r);
            check("R7 R9 lo readback idle", r, {lo_w[31:13], 1'b0, lo_w[11:0]});
        end
        check("R8 no error yet", {31'h0, err_sticky}, 32'h0);

        // Refused launch and high-word rewrite while busy
        hi_w = 32'hA5000000;
        lo_a = 32'h0000C5FE;   // INIT-class mode 5, assert, level, vector FE
        wr(HI, hi_w);
        wr(LO, lo_a);
        held = act_msg();
        check("R4 snapshot", {8'h0, held}, {8'h0, exp_msg(hi_w, lo_a)});
        wr(LO, 32'h00080612);
        rd(LO, r); check("R8 lo kept", r, {lo_a[31:13], 1'b1, lo_a[11:0]});
        check("R8 err set", {31'h0, err_sticky}, 32'h1);
        check("R8 msg kept", {8'h0, act_msg()}, {8'h0, held});
        hi_b = 32'h3C00_1234;
        wr(HI, hi_b);
        rd(HI, r); check("R2 hi rewrite", r, hi_b);
        check("R6 dest unchanged", {8'h0, act_msg()}, {8'h0, held});
        check("R6 still valid", {31'h0, msg_valid}, 32'h1);
        accept();
        check("R7 drop", {31'h0, msg_valid}, 32'h0);
        check("R8 err stays", {31'h0, err_sticky}, 32'h1);

        // Unmapped offset
        wr(12'h320, 32'hFFFFFFFF);
        rd(12'h320, r); check("R10 unmapped read", r, 32'h0);
        rd(HI, r); check("R10 hi untouched", r, hi_b);
        rd(LO, r); check("R10 lo untouched", r, {lo_a[31:13], 1'b0, lo_a[11:0]});
        check("R10 no launch", {31'h0, msg_valid}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule